// File: doc/BRIEF.md
# Edge Capture Timer with Prescaler

This block is a 16-bit down-counting timer for a small byte-oriented processor. A programmable divider slows the system clock, and each divider period the counter steps down by one, wrapping from zero to all ones and flagging that wrap. An external input is resynchronised to the system clock. On the edge direction software has chosen, the current count is copied into a capture register and a second flag is raised.

Software reaches the block through a byte-wide register port with a 2-bit address, write data, a write strobe and registered read data. Four locations are decoded: control/status, divider value, and the low and high bytes of the captured count. The interrupt request is high while interrupts are enabled and either flag is pending. A second timer is obtained by instantiating the block again.

Top module: `edge_capture_timer`

## Requirements
- R1: After a synchronous reset every register (control, divider, capture, count) is 0, `irq` is 0 and `rd_data` is 0.
- R2: Address 0 reads the control byte with bit 0 run, bit 1 interrupt enable, bit 2 wrap pending, bit 3 capture pending, bit 4 edge select, bit 7 reserved, and bits 5 and 6 always 0. Address 1 reads the divider, address 2 the capture low byte and address 3 the capture high byte. `rd_data` shows the location addressed in the previous cycle.
- R3: With run at 1 and divider value P, the count decreases by exactly one every P+1 clocks.
- R4: With run at 0 the count keeps its value, and the divider restarts from zero.
- R5: A decrement from 0x0000 gives 0xFFFF and sets the wrap pending bit (bit 2). Counting then continues.
- R6: With edge select 0, a rising input edge is detected after a two-flop synchroniser (third clock edge after the input changes). In that clock the current count is copied into the capture register and capture pending (bit 3) is set. Capture does not depend on run.
- R7: With edge select 1 only falling edges capture. The edge direction that is not selected leaves the capture register and bit 3 unchanged.
- R8: A control write with 0 in bit 2 or bit 3 clears that pending bit, and a 1 leaves it unchanged. If hardware sets a bit in the same clock as a clearing write, the bit ends up set.
- R9: `irq` equals interrupt enable AND (wrap pending OR capture pending), with the state of the current cycle.
- R10: Writes to addresses 2 and 3 do not change the capture bytes. Bit 7 of the control byte is stored and read back, and it has no effect on counting or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Registered read data |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults: an 8-bit data width, which gives a 16-bit count, and a two-stage synchroniser. At divider value 0 the count steps every clock. Because the count starts at 0 after reset, the first decrement reaches the wrap case at once, and any ignored edge that wrongly captured would be visible in the low byte. At divider value 3, two captures spaced 16 clocks apart must differ by exactly 4. A write timed onto the capture clock exercises the case where the hardware set meets a clearing write.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 2'd0,
    A_DIV  = 2'd1,
    A_CAPL = 2'd2,
    A_CAPH = 2'd3
  } reg_addr_t;

  // control byte layout
  localparam int B_RUN  = 0;
  localparam int B_IEN  = 1;
  localparam int B_WRAP = 2;
  localparam int B_CAPP = 3;
  localparam int B_EDGE = 4;
  localparam int B_RSV  = 7;
endpackage

// File: rtl/ect_divider.sv
module ect_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  assign tick = run && (phase_q == div_val);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || div_val == '0)); // R3
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] count_q;

  assign count = count_q;
  assign wrap  = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q - 1'b1;
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count_q)); // R4
  AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count_q == '1)); // R5
endmodule

// File: rtl/ect_capture.sv
module ect_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_in,
  input  logic             edge_fall,
  input  logic [CNT_W-1:0] count,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0]     sh_q;
  logic [CNT_W-1:0] cap_q;
  logic             now_s, prev_s;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[TOP-1:0], cap_in};
  end

  assign now_s   = sh_q[TOP-1];
  assign prev_s  = sh_q[TOP];
  assign cap_evt = edge_fall ? (prev_s && !now_s) : (now_s && !prev_s);

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= count;
  end

  assign cap_val = cap_q;

  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_q == $past(count))); // R6
  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(cap_q)); // R7
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cap_in,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int DIV_W = DATA_W;

  logic             run_q, ien_q, edge_q, rsv_q, wrap_q, capp_q;
  logic [DIV_W-1:0] div_q;
  logic [DATA_W-1:0] rd_q;
  logic             irq_q;
  logic             tick, wrap_evt, cap_evt;
  logic [CNT_W-1:0] count, cap_val;
  logic             ctrl_wr, div_wr;
  logic             wrap_n, capp_n, ien_n;
  logic [7:0]       ctrl_byte;

  ect_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .div_val(div_q), .tick(tick)
  );

  ect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick), .count(count), .wrap(wrap_evt)
  );

  ect_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .cap_in(cap_in), .edge_fall(edge_q),
    .count(count), .cap_evt(cap_evt), .cap_val(cap_val)
  );

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign div_wr  = wr_en && (addr == A_DIV);

  always_comb begin
    ien_n  = ctrl_wr ? wr_data[B_IEN] : ien_q;
    wrap_n = ((ctrl_wr ? wr_data[B_WRAP] : 1'b1) && wrap_q) || wrap_evt;
    capp_n = ((ctrl_wr ? wr_data[B_CAPP] : 1'b1) && capp_q) || cap_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      edge_q <= 1'b0;
      rsv_q  <= 1'b0;
      wrap_q <= 1'b0;
      capp_q <= 1'b0;
      div_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= wr_data[B_RUN];
        edge_q <= wr_data[B_EDGE];
        rsv_q  <= wr_data[B_RSV];
      end
      if (div_wr) div_q <= wr_data[DIV_W-1:0];
      ien_q  <= ien_n;
      wrap_q <= wrap_n;
      capp_q <= capp_n;
      irq_q  <= ien_n && (wrap_n || capp_n);
    end
  end

  always_comb begin
    ctrl_byte         = '0;
    ctrl_byte[B_RUN]  = run_q;
    ctrl_byte[B_IEN]  = ien_q;
    ctrl_byte[B_WRAP] = wrap_q;
    ctrl_byte[B_CAPP] = capp_q;
    ctrl_byte[B_EDGE] = edge_q;
    ctrl_byte[B_RSV]  = rsv_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (reg_addr_t'(addr))
        A_CTRL:  rd_q <= DATA_W'(ctrl_byte);
        A_DIV:   rd_q <= div_q;
        A_CAPL:  rd_q <= cap_val[DATA_W-1:0];
        default: rd_q <= cap_val[CNT_W-1:DATA_W];
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wrap_q && !(ctrl_wr && !wr_data[B_WRAP])) |=> wrap_q); // R8
  AST_CAPP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (capp_q && !(ctrl_wr && !wr_data[B_CAPP])) |=> capp_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> capp_q); // R8
  AST_IRQ_EQN: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ien_q && (wrap_q || capp_q))); // R9
endmodule

// File: tb/edge_capture_timer_test.sv
module edge_capture_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_en = 1'b0;
  logic       cap_in = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  edge_capture_timer uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data(rd_data), .cap_in(cap_in), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference, advanced once per rising edge
  bit [15:0] m_cnt, m_cap;
  bit [7:0]  m_div, m_phase, m_rd;
  bit        m_run, m_ien, m_edge, m_rsv, m_wrap, m_capp, m_irq;
  bit        m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    bit tk, wr_ev, ev;
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_div = 0; m_phase = 0; m_rd = 0;
      m_run = 0; m_ien = 0; m_edge = 0; m_rsv = 0; m_wrap = 0; m_capp = 0;
      m_irq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      tk    = m_run && (m_phase == m_div);
      wr_ev = tk && (m_cnt == 16'h0000);
      ev    = m_edge ? (m_s3 && !m_s2) : (m_s2 && !m_s3);
      case (addr)
        2'd0: m_rd = {m_rsv, 2'b00, m_edge, m_capp, m_wrap, m_ien, m_run};
        2'd1: m_rd = m_div;
        2'd2: m_rd = m_cap[7:0];
        default: m_rd = m_cap[15:8];
      endcase
      if (ev) m_cap = m_cnt;
      if (tk) m_cnt = m_cnt - 16'd1;
      m_phase = (!m_run || tk) ? 8'd0 : m_phase + 8'd1;
      if (wr_en && addr == 2'd0) begin
        m_run = wr_data[0]; m_ien = wr_data[1]; m_edge = wr_data[4]; m_rsv = wr_data[7];
        m_wrap = m_wrap && wr_data[2];
        m_capp = m_capp && wr_data[3];
      end
      if (wr_en && addr == 2'd1) m_div = wr_data;
      m_wrap = m_wrap || wr_ev;
      m_capp = m_capp || ev;
      m_irq  = m_ien && (m_wrap || m_capp);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== m_rd) begin
        errors++;
        $display("FAIL R2/R6 rd_data actual %h expected %h at cycle %0d", rd_data, m_rd, cycles);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R9 irq actual %b expected %b at cycle %0d", irq, m_irq, cycles);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    bit [7:0] v, a_lo, a_hi, b_lo, b_hi;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", irq, 0);

    // R5 wrap from zero at divider 0
    wr(2'd0, 8'h01);
    idle(4);
    rd(2'd0, v);
    chk("R5 wrap pending", v[2], 1);
    cap_in = 1'b1;
    idle(4);
    rd(2'd3, v);
    chk("R5 keeps counting below 0xFFFF", v, 8'hFF);
    rd(2'd0, v);
    chk("R6 capture pending on rising", v[3], 1);

    // R9 interrupt
    chk("R9 irq off while disabled", irq, 0);
    wr(2'd0, 8'h0F);
    chk("R9 irq on when enabled", irq, 1);
    wr(2'd0, 8'h03);
    chk("R9 irq off when cleared", irq, 0);
    rd(2'd0, v);
    chk("R8 write 0 clears both", v[3:2], 0);

    // R7 edge direction
    rd(2'd2, a_lo);
    cap_in = 1'b0;
    idle(5);
    rd(2'd0, v);
    chk("R7 falling ignored on rising select", v[3], 0);
    rd(2'd2, v);
    chk("R7 capture unchanged", v, a_lo);
    wr(2'd0, 8'h13);
    cap_in = 1'b1;
    idle(5);
    rd(2'd0, v);
    chk("R7 rising ignored on falling select", v[3], 0);
    cap_in = 1'b0;
    idle(5);
    rd(2'd0, v);
    chk("R7 falling captures", v[3], 1);
    chk("R9 irq on capture", irq, 1);

    // R8 sticky and set-wins
    wr(2'd0, 8'h1F);
    rd(2'd0, v);
    chk("R8 write 1 keeps", v[3], 1);
    wr(2'd0, 8'h13);
    cap_in = 1'b1;
    idle(3);
    cap_in = 1'b0;
    idle(2);
    addr = 2'd0; wr_data = 8'h13; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd0, v);
    chk("R8 hardware set wins over clear", v[3], 1);

    // R2 map and reserved bits, R10 reserved bit stored
    wr(2'd1, 8'hA5);
    rd(2'd1, v);
    chk("R2 divider readback", v, 8'hA5);
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    chk("R2 bits 5-6 read zero", v & 8'h60, 0);
    chk("R10 reserved bit stored", v[7], 1);

    // R10 capture bytes not writable
    rd(2'd2, a_lo);
    rd(2'd3, a_hi);
    wr(2'd2, 8'h55);
    wr(2'd3, 8'hAA);
    rd(2'd2, v);
    chk("R10 capture low unchanged", v, a_lo);
    rd(2'd3, v);
    chk("R10 capture high unchanged", v, a_hi);

    // R3 period with divider 3
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h01);
    idle(3);
    cap_in = 1'b1;
    idle(4);
    cap_in = 1'b0;
    rd(2'd2, a_lo);
    rd(2'd3, a_hi);
    idle(10);
    cap_in = 1'b1;
    idle(4);
    rd(2'd2, b_lo);
    rd(2'd3, b_hi);
    cap_in = 1'b0;
    chk("R3 four steps in sixteen clocks", 16'({a_hi, a_lo} - {b_hi, b_lo}), 4);

    // R4 stopped count holds
    wr(2'd0, 8'h00);
    idle(3);
    cap_in = 1'b1;
    idle(4);
    cap_in = 1'b0;
    rd(2'd2, a_lo);
    rd(2'd3, a_hi);
    idle(20);
    cap_in = 1'b1;
    idle(4);
    rd(2'd2, b_lo);
    rd(2'd3, b_hi);
    chk("R4 count held while stopped", {b_hi, b_lo}, {a_hi, a_lo});
    rd(2'd0, v);
    chk("R6 capture works while stopped", v[3], 1);

    idle(2);
    finish_run();
  end
endmodule